// File: doc/BRIEF.md
# Two-Sample Agreement Input Filter

This block removes short glitches from eight binary input channels before they are latched as input states. A shared prescaler divides a free-running oscillator tick, presented as a one-cycle enable, by 8 or by 64. It produces a filter sample tick. A static select input chooses the ratio. Each channel first passes through a two-flop synchronizer in the system clock domain. It then feeds a pair of sample flip-flops that advance only on the filter tick.

A set/reset output stage drives each filtered output. The output goes high when the two held samples are both high, goes low when both are low, and otherwise keeps its value. A level change on an input therefore reaches the output after no less than two and no more than three filter periods. A pulse that fits between two sample ticks is never seen.

When the divider select changes, the prescaler count restarts from zero. The first filter period after the change is a full period of the new ratio.

Top module: `agree_filter`

## Requirements
- R1: A synchronous active-high reset drives every filtered output to 0 on the clock edge where reset is sampled high, and clears the prescaler and the sample stages.
- R2: With `div_sel` = 0 the filter tick occurs once every 8 oscillator ticks.
- R3: With `div_sel` = 1 the filter tick occurs once every 64 oscillator ticks.
- R4: A steady new input level appears on the output no earlier than 2×ratio clock cycles after it is applied. With the oscillator tick high every cycle, it appears no later than 3×ratio+4 cycles after it is applied.
- R5: The filtered outputs change only in the cycle that follows a filter tick. A single level change on an input therefore produces exactly one output transition.
- R6: An input pulse shorter than one filter period does not change the filtered output, for either pulse polarity.
- R7: An output is set only when its two most recent samples are both 1 and cleared only when both are 0. An input that alternates on every sample therefore leaves the output unchanged.
- R8: A change of `div_sel` restarts the prescaler count at zero, and no filter tick occurs in the cycle after the change.
- R9: Each channel is filtered independently. Bit i of `filt_out` depends only on bit i of `raw_in`.
- R10: While `osc_tick` is low, no filter tick occurs and the outputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_tick | input | 1 | One-cycle enable from the filter oscillator |
| div_sel | input | 1 | Divider select: 0 for ratio 8, 1 for ratio 64 |
| raw_in | input | 8 | Unfiltered comparator outputs, one per channel |
| filt_out | output | 8 | Filtered input states, one per channel |

## Verification
The assertions assume that `div_sel` is static between transfers and changes at most occasionally. They also assume that `osc_tick` is a plain enable that may stay high or low for any number of cycles. The bench drives all inputs on the falling clock edge, holds `div_sel` for whole test steps, and keeps the oscillator tick high except during the frozen-oscillator test. The timing windows in the bench come from the ratio bounds alone and are sampled well inside them. The results therefore do not depend on the prescaler phase at the moment a pattern is applied.

// File: rtl/agree_filter_pkg.sv
package agree_filter_pkg;

    typedef enum logic {
        RATIO_FAST = 1'b0,
        RATIO_SLOW = 1'b1
    } ratio_sel_e;

    typedef struct packed {
        logic newer;
        logic older;
    } sample_pair_t;

    function automatic int unsigned ratio_last(input ratio_sel_e sel,
                                               input int unsigned lo,
                                               input int unsigned hi);
        return (sel == RATIO_SLOW) ? hi - 1 : lo - 1;
    endfunction

endpackage

// File: rtl/agree_filter_sync.sv
module agree_filter_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] meta_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            q_o    <= '0;
        end else begin
            meta_q <= d_i;
            q_o    <= meta_q;
        end
    end
endmodule

// File: rtl/agree_filter_prescale.sv
module agree_filter_prescale
    import agree_filter_pkg::*;
#(
    parameter int DIV_LO = 8,
    parameter int DIV_HI = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic osc_tick,
    input  logic div_sel,
    output logic tick_o
);
    localparam int CW = $clog2(DIV_HI);

    ratio_sel_e    sel_now;
    ratio_sel_e    sel_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_last;

    assign sel_now  = ratio_sel_e'(div_sel);
    assign cnt_last = CW'(ratio_last(sel_now, DIV_LO, DIV_HI));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            sel_q  <= sel_now;
            tick_o <= 1'b0;
        end else if (sel_now != sel_q) begin
            sel_q  <= sel_now;
            cnt_q  <= '0;
            tick_o <= 1'b0;
        end else if (osc_tick) begin
            if (cnt_q == cnt_last) begin
                cnt_q  <= '0;
                tick_o <= 1'b1;
            end else begin
                cnt_q  <= cnt_q + 1'b1;
                tick_o <= 1'b0;
            end
        end else begin
            tick_o <= 1'b0;
        end
    end
endmodule

// File: rtl/agree_filter_chan.sv
module agree_filter_chan
    import agree_filter_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    input  logic d_i,
    output logic q_o
);
    sample_pair_t smp_q;
    logic         set_w;
    logic         clr_w;

    assign set_w = smp_q.newer & smp_q.older;
    assign clr_w = ~(smp_q.newer | smp_q.older);

    always_ff @(posedge clk) begin
        if (rst) begin
            smp_q <= '0;
            q_o   <= 1'b0;
        end else if (tick_i) begin
            smp_q.newer <= d_i;
            smp_q.older <= smp_q.newer;
            if (set_w) begin
                q_o <= 1'b1;
            end else if (clr_w) begin
                q_o <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/agree_filter.sv
module agree_filter #(
    parameter int N_CH   = 8,
    parameter int DIV_LO = 8,
    parameter int DIV_HI = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            osc_tick,
    input  logic            div_sel,
    input  logic [N_CH-1:0] raw_in,
    output logic [N_CH-1:0] filt_out
);
    logic [N_CH-1:0] sync_w;
    logic            tick_w;

    agree_filter_sync #(.WIDTH(N_CH)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (raw_in),
        .q_o (sync_w)
    );

    agree_filter_prescale #(.DIV_LO(DIV_LO), .DIV_HI(DIV_HI)) u_pre (
        .clk      (clk),
        .rst      (rst),
        .osc_tick (osc_tick),
        .div_sel  (div_sel),
        .tick_o   (tick_w)
    );

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_chan
        agree_filter_chan u_chan (
            .clk    (clk),
            .rst    (rst),
            .tick_i (tick_w),
            .d_i    (sync_w[ch]),
            .q_o    (filt_out[ch])
        );
    end
endmodule

// File: rtl/agree_filter_checker.sv
module agree_filter_checker #(
    parameter int N_CH = 8
) (
    input logic            clk,
    input logic            rst,
    input logic            osc_tick,
    input logic            div_sel,
    input logic            tick_w,
    input logic [N_CH-1:0] filt_out
);
    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (filt_out == '0)); // R1

    AST_HOLD_WITHOUT_TICK: assert property (@(posedge clk) disable iff (rst)
        !tick_w |=> $stable(filt_out)); // R5

    AST_TICK_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        tick_w |=> !tick_w); // R2

    AST_SEL_CHANGE_RESTART: assert property (@(posedge clk) disable iff (rst)
        !$stable(div_sel) |=> !tick_w); // R8

    AST_NO_OSC_NO_TICK: assert property (@(posedge clk) disable iff (rst)
        !osc_tick |=> !tick_w); // R10
endmodule

bind agree_filter agree_filter_checker #(.N_CH(N_CH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .osc_tick (osc_tick),
    .div_sel  (div_sel),
    .tick_w   (tick_w),
    .filt_out (filt_out)
);

// File: tb/agree_filter_bench.sv
module agree_filter_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       osc_tick = 1'b1;
    logic       div_sel = 1'b0;
    logic [7:0] raw_in = '0;
    logic [7:0] filt_out;

    int checks = 0;
    int errors = 0;
    logic [7:0] prev_exp = '0;

    always #5 clk = ~clk;

    agree_filter u_agree_filter (
        .clk      (clk),
        .rst      (rst),
        .osc_tick (osc_tick),
        .div_sel  (div_sel),
        .raw_in   (raw_in),
        .filt_out (filt_out)
    );

    // {div_sel, pattern}
    localparam logic [8:0] VEC [6] = '{
        {1'b0, 8'hA5},
        {1'b0, 8'h5A},
        {1'b0, 8'hFF},
        {1'b1, 8'h0F},
        {1'b1, 8'hF0},
        {1'b0, 8'h00}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R4 actual running expected finished");
        finish_run();
    end

    initial begin
        @(negedge clk);
        raw_in = 8'hFF;
        wait_n(3);
        check("R1 reset state", filt_out, 8'h00);
        rst = 1'b0;
        raw_in = 8'h00;
        wait_n(4);
        check("R1 after release", filt_out, 8'h00);

        // R2 R3 R4 R5 R8 R9: table walk
        foreach (VEC[i]) begin
            int ratio;
            int changes;
            logic [7:0] last;
            div_sel = VEC[i][8];
            raw_in  = VEC[i][7:0];
            ratio   = VEC[i][8] ? 64 : 8;
            changes = 0;
            last    = filt_out;
            for (int c = 0; c < 2 * ratio; c++) begin
                @(negedge clk);
                if (filt_out !== last) changes++;
                last = filt_out;
            end
            check(VEC[i][8] ? "R3 R8 no early change" : "R2 R4 no early change",
                  filt_out, prev_exp);
            for (int c = 0; c < ratio + 4; c++) begin
                @(negedge clk);
                if (filt_out !== last) changes++;
                last = filt_out;
            end
            check(VEC[i][8] ? "R3 R9 late value" : "R2 R4 R9 late value",
                  filt_out, VEC[i][7:0]);
            check("R5 transition count", 8'(changes), (VEC[i][7:0] != prev_exp) ? 8'd1 : 8'd0);
            prev_exp = VEC[i][7:0];
        end

        // R6: short high pulse, ratio 8
        div_sel = 1'b0;
        raw_in = 8'h00;
        wait_n(40);
        raw_in = 8'h3C;
        wait_n(7);
        raw_in = 8'h00;
        wait_n(40);
        check("R6 short high pulse", filt_out, 8'h00);

        // R6: short low pulse
        raw_in = 8'hFF;
        wait_n(40);
        check("R4 steady high", filt_out, 8'hFF);
        raw_in = 8'h81;
        wait_n(7);
        raw_in = 8'hFF;
        wait_n(40);
        check("R6 short low pulse", filt_out, 8'hFF);

        // R7: alternate every sample period, output holds
        for (int k = 0; k < 12; k++) begin
            raw_in = k[0] ? 8'hFF : 8'h00;
            wait_n(8);
        end
        check("R7 alternating input holds", filt_out, 8'hFF);

        // R10: frozen oscillator
        raw_in = 8'hFF;
        wait_n(40);
        osc_tick = 1'b0;
        raw_in = 8'h00;
        wait_n(200);
        check("R10 frozen oscillator holds", filt_out, 8'hFF);
        osc_tick = 1'b1;
        wait_n(28);
        check("R10 resumes after oscillator", filt_out, 8'h00);

        // R1: reset mid-run clears outputs
        raw_in = 8'hC3;
        wait_n(40);
        check("R9 per-channel pattern", filt_out, 8'hC3);
        rst = 1'b1;
        wait_n(1);
        check("R1 mid-run reset", filt_out, 8'h00);
        rst = 1'b0;
        wait_n(40);
        check("R4 after reset", filt_out, 8'hC3);

        finish_run();
    end
endmodule